// File: doc/BRIEF.md
# NAND Image Loader With Bad-Block Skipping

This block copies a contiguous image out of a NAND array into a destination memory. A host gives it a start offset (which must fall on a page boundary), a byte length and a destination base address, then pulses `start`. From these inputs the loader works out the first erase block, the last erase block and the page to begin at. It then visits the blocks one after another.

For each block, the loader first reads that block's bad-block marker through a spare-area read. A block whose marker is not all ones is skipped. Each skipped block pushes the end of the range out by one block, so the image still occupies the same number of good blocks. In a good block, every page from the current page to the end of the block is fetched, one bus word per read strobe. Each word is then written to the destination at an address that runs on without a break across pages and blocks.

The command/address sequencing towards the array lives in a separate sequencer. The loader reaches it through a request/done handshake that carries a row, a column and a spare-area flag. Error correction is not part of this block.

Top module: `nand_image_loader`

## Requirements
- R1: At an accepted start, the first block is offset / block bytes, the last block is (offset + length - 1) / block bytes, and the starting page is (offset mod block bytes) / page bytes. The first normal page read uses row = first block * pages per block + starting page, column 0 and `seq_spare` = 0.
- R2: Before any page of a block is read, the loader issues one spare-area command (`seq_spare` = 1, row = block * pages per block, column = marker byte column / bytes per word). It follows this command with exactly one `rd_en` strobe.
- R3: A block is bad when the marker word returned after that strobe is not all ones: any value other than 0xFF on an 8-bit bus, or 0xFFFF on a 16-bit bus. The values 0x00, 0xFE and 0x7F all count as bad.
- R4: In a good block, the loader issues one normal read command per page, from the current page up to the last page of the block, in ascending order. Each command is followed by words-per-page `rd_en` strobes. The page index restarts at 0 for the following block.
- R5: The word on `rd_data` in the cycle after each page-read strobe is written with `mem_we`, two cycles after that strobe. The write addresses are `dst_base`, `dst_base` + bytes per word, and so on, with no gap between pages or blocks.
- R6: A bad block gets no page reads, and the last-block index grows by one. The page index is left unchanged, so a bad first block passes its starting page on to the next good block.
- R7: Loading ends once the block index passes the last-block index. Every page is transferred in full, even past the requested length.
- R8: `busy` is high from the cycle after an accepted start until completion. `done` is high for exactly one cycle, with `busy` low in that cycle. A `start` pulse while `busy` is high is ignored.
- R9: A start whose offset is not page aligned sets `fault`. It issues no command, makes no write and leaves `busy` low. `fault` clears at the next accepted start.
- R10: A start with length 0 (and an aligned offset) pulses `done` in the next cycle and issues no command.
- R11: If the block index would reach the device block count before passing the last-block index, loading stops with `done` and `fault`.
- R12: `seq_req` stays high until `seq_done` is seen, and it is low in the cycle after `seq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load; sampled only while idle |
| load_ofs | input | OFS_W (10) | Byte offset of the image in the array |
| load_len | input | OFS_W+1 (11) | Image length in bytes |
| dst_base | input | ADDR_W (16) | Destination byte address of the first word |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Misaligned offset or end of device reached |
| seq_req | output | 1 | Command request to the sequencer |
| seq_spare | output | 1 | Request targets the spare area |
| seq_row | output | ROW_W (6) | Page row: block * pages per block + page |
| seq_col | output | COL_W (8) | Column in bus words |
| seq_done | input | 1 | Sequencer has finished the request |
| rd_en | output | 1 | Read-enable strobe, one bus word each |
| rd_data | input | BUS_W (8) | Word returned in the cycle after a strobe |
| mem_we | output | 1 | Destination write valid |
| mem_addr | output | ADDR_W (16) | Destination byte address |
| mem_wdata | output | BUS_W (8) | Destination write data |

## Verification
The bench builds the loader with an 8-bit bus, 16-byte pages, 4 pages per block and 16 blocks. At that size, each page-aligned offset across the first three blocks can be combined with lengths of 1, 17, 64 and 100 bytes, under both a clean and a damaged bad-block map. This covers start pages in every position, lengths that end mid-page, and a bad first block that carries its start page forward. The small block count also keeps the device end close: a run of bad blocks, or a length that overshoots the array, reaches the fault exit within a few hundred cycles.

// File: rtl/nil_pkg.sv
package nil_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHK_REQ,
    S_CHK_RD,
    S_CHK_EVAL,
    S_PG_REQ,
    S_PG_XFER,
    S_STEP
  } nil_state_e;

endpackage

// File: rtl/nil_geom.sv
// Splits the load offset and length into block and page indices.
// All geometry sizes are powers of two, so the divides are plain shifts.
module nil_geom #(
  parameter int PG_SH  = 4,
  parameter int PG_W   = 2,
  parameter int OFS_W  = 10,
  parameter int SIZE_W = 11,
  parameter int BC_W   = 6
) (
  input  logic [OFS_W-1:0]  ofs,
  input  logic [SIZE_W-1:0] len,
  output logic [BC_W-1:0]   first_blk,
  output logic [BC_W-1:0]   last_blk,
  output logic [PG_W-1:0]   start_pg,
  output logic              aligned,
  output logic              len_zero
);
  localparam int BLK_SH = PG_SH + PG_W;
  localparam int END_W  = SIZE_W + 1;

  logic [END_W-1:0] end_byte;

  always_comb begin
    end_byte  = END_W'(ofs) + END_W'(len) - END_W'(1);
    first_blk = BC_W'(ofs >> BLK_SH);
    last_blk  = BC_W'(end_byte >> BLK_SH);
    start_pg  = ofs[BLK_SH-1:PG_SH];
    aligned   = (ofs[PG_SH-1:0] == '0);
    len_zero  = (len == '0);
  end

endmodule

// File: rtl/nil_stream.sv
// Page streamer: issues one strobe per bus word and forwards each returned
// word to the destination write port at a running byte address.
module nil_stream #(
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 16,
  parameter int WPP    = 16,
  parameter int STEP   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              go,
  input  logic [BUS_W-1:0]  rd_data,
  output logic              rd_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BUS_W-1:0]  mem_wdata,
  output logic              fin
);
  localparam int CNT_W = $clog2(WPP + 1);

  logic              rd_q,   rd_d;
  logic [CNT_W-1:0]  icnt_q, icnt_d;
  logic              cap_q,  cap_d;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d;
  logic [ADDR_W-1:0] wptr_q, wptr_d;
  logic              we_q,   we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BUS_W-1:0]  wdat_q, wdat_d;
  logic              fin_q,  fin_d;

  always_comb begin
    rd_d   = rd_q;
    icnt_d = icnt_q;
    if (go) begin
      rd_d   = 1'b1;
      icnt_d = '0;
    end else if (rd_q) begin
      icnt_d = icnt_q + CNT_W'(1);
      if (icnt_q == CNT_W'(WPP - 1)) rd_d = 1'b0;
    end

    cap_d  = rd_q;
    we_d   = cap_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    if (cap_q) begin
      addr_d = wptr_q;
      wdat_d = rd_data;
    end

    wptr_d = wptr_q;
    if (ld)         wptr_d = ld_addr;
    else if (cap_q) wptr_d = wptr_q + ADDR_W'(STEP);

    wcnt_d = wcnt_q;
    if (go)         wcnt_d = '0;
    else if (cap_q) wcnt_d = wcnt_q + CNT_W'(1);

    fin_d = cap_q && (wcnt_q == CNT_W'(WPP - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      icnt_q <= '0;
      cap_q  <= 1'b0;
      wcnt_q <= '0;
      wptr_q <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      fin_q  <= 1'b0;
    end else begin
      rd_q   <= rd_d;
      icnt_q <= icnt_d;
      cap_q  <= cap_d;
      wcnt_q <= wcnt_d;
      wptr_q <= wptr_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      fin_q  <= fin_d;
    end
  end

  assign rd_en     = rd_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdat_q;
  assign fin       = fin_q;

  // R5: back-to-back writes sit on consecutive word addresses
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(STEP)));

  // R5: every write follows a strobe two cycles earlier
  a_r5_we_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(rd_en, 2));

endmodule

// File: rtl/nil_ctrl.sv
// Block walker: marker check, page sequencing, range extension, completion.
module nil_ctrl
  import nil_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int PG_W       = 2,
  parameter int DBLK_W     = 4,
  parameter int BC_W       = 6,
  parameter int NUM_BLOCKS = 16,
  parameter int COL_W      = 8,
  parameter int MARK_WCOL  = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   aligned,
  input  logic                   len_zero,
  input  logic [BC_W-1:0]        first_blk,
  input  logic [BC_W-1:0]        last_blk,
  input  logic [PG_W-1:0]        start_pg,
  input  logic                   seq_done,
  input  logic [BUS_W-1:0]       rd_data,
  input  logic                   xfer_fin,
  output logic                   seq_req,
  output logic                   seq_spare,
  output logic [DBLK_W+PG_W-1:0] seq_row,
  output logic [COL_W-1:0]       seq_col,
  output logic                   chk_rd,
  output logic                   xfer_go,
  output logic                   accept,
  output logic                   busy,
  output logic                   done,
  output logic                   fault
);
  nil_state_e      st_q, st_d;
  logic [BC_W-1:0] blk_q, blk_d;
  logic [BC_W-1:0] last_q, last_d;
  logic [PG_W-1:0] pg_q, pg_d;
  logic            flt_q, flt_d;
  logic            dn_q, dn_d;
  logic [BC_W-1:0] blk_nx;
  logic            mark_ok;

  assign blk_nx  = blk_q + BC_W'(1);
  assign mark_ok = &rd_data;

  always_comb begin
    st_d   = st_q;
    blk_d  = blk_q;
    last_d = last_q;
    pg_d   = pg_q;
    flt_d  = flt_q;
    dn_d   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          if (!aligned) begin
            flt_d = 1'b1;
          end else if (len_zero) begin
            dn_d  = 1'b1;
            flt_d = 1'b0;
          end else begin
            blk_d  = first_blk;
            last_d = last_blk;
            pg_d   = start_pg;
            flt_d  = 1'b0;
            st_d   = S_CHK_REQ;
          end
        end
      end
      S_CHK_REQ: if (seq_done) st_d = S_CHK_RD;
      S_CHK_RD:  st_d = S_CHK_EVAL;
      S_CHK_EVAL: begin
        if (mark_ok) begin
          st_d = S_PG_REQ;
        end else begin
          last_d = last_q + BC_W'(1);
          st_d   = S_STEP;
        end
      end
      S_PG_REQ: if (seq_done) st_d = S_PG_XFER;
      S_PG_XFER: begin
        if (xfer_fin) begin
          if (&pg_q) begin
            pg_d = '0;
            st_d = S_STEP;
          end else begin
            pg_d = pg_q + PG_W'(1);
            st_d = S_PG_REQ;
          end
        end
      end
      S_STEP: begin
        blk_d = blk_nx;
        if (blk_nx > last_q) begin
          dn_d = 1'b1;
          st_d = S_IDLE;
        end else if (blk_nx == BC_W'(NUM_BLOCKS)) begin
          dn_d  = 1'b1;
          flt_d = 1'b1;
          st_d  = S_IDLE;
        end else begin
          st_d = S_CHK_REQ;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      blk_q  <= '0;
      last_q <= '0;
      pg_q   <= '0;
      flt_q  <= 1'b0;
      dn_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      blk_q  <= blk_d;
      last_q <= last_d;
      pg_q   <= pg_d;
      flt_q  <= flt_d;
      dn_q   <= dn_d;
    end
  end

  always_comb begin
    seq_req   = (st_q == S_CHK_REQ) || (st_q == S_PG_REQ);
    seq_spare = (st_q == S_CHK_REQ);
    seq_row   = {blk_q[DBLK_W-1:0], (st_q == S_PG_REQ) ? pg_q : PG_W'(0)};
    seq_col   = seq_spare ? COL_W'(MARK_WCOL) : '0;
    chk_rd    = (st_q == S_CHK_RD);
    xfer_go   = (st_q == S_PG_REQ) && seq_done;
    accept    = (st_q == S_IDLE) && start && aligned && !len_zero;
    busy      = (st_q != S_IDLE);
    done      = dn_q;
    fault     = flt_q;
  end

  // R12: request held until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && !seq_done) |=> seq_req);

  // R12: request withdrawn right after acknowledge
  a_r12_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && seq_done) |=> !seq_req);

  // R8: completion pulse only while not busy, and every end of busy has one
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r8_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9: misaligned start faults and stays idle
  a_r9_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !aligned) |=> (fault && !busy && !seq_req));

  // R10: zero length completes at once
  a_r10_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && aligned && len_zero) |=> (done && !busy));

endmodule

// File: rtl/nand_image_loader.sv
module nand_image_loader #(
  parameter int BUS_W           = 8,
  parameter int PAGE_BYTES      = 16,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int NUM_BLOCKS      = 16,
  parameter int COL_W           = 8,
  parameter int MARK_COL        = 0,
  parameter int ADDR_W          = 16,
  localparam int BPW    = BUS_W / 8,
  localparam int WPP    = PAGE_BYTES / BPW,
  localparam int PG_SH  = $clog2(PAGE_BYTES),
  localparam int PG_W   = $clog2(PAGES_PER_BLOCK),
  localparam int DBLK_W = $clog2(NUM_BLOCKS),
  localparam int OFS_W  = PG_SH + PG_W + DBLK_W,
  localparam int SIZE_W = OFS_W + 1,
  localparam int BC_W   = DBLK_W + 2,
  localparam int ROW_W  = DBLK_W + PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OFS_W-1:0]  load_ofs,
  input  logic [SIZE_W-1:0] load_len,
  input  logic [ADDR_W-1:0] dst_base,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              seq_req,
  output logic              seq_spare,
  output logic [ROW_W-1:0]  seq_row,
  output logic [COL_W-1:0]  seq_col,
  input  logic              seq_done,
  output logic              rd_en,
  input  logic [BUS_W-1:0]  rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BUS_W-1:0]  mem_wdata
);
  logic [BC_W-1:0] first_blk, last_blk;
  logic [PG_W-1:0] start_pg;
  logic            aligned, len_zero;
  logic            chk_rd, xfer_go, accept, xfer_fin, st_rd;

  nil_geom #(
    .PG_SH (PG_SH),
    .PG_W  (PG_W),
    .OFS_W (OFS_W),
    .SIZE_W(SIZE_W),
    .BC_W  (BC_W)
  ) u_geom (
    .ofs      (load_ofs),
    .len      (load_len),
    .first_blk(first_blk),
    .last_blk (last_blk),
    .start_pg (start_pg),
    .aligned  (aligned),
    .len_zero (len_zero)
  );

  nil_ctrl #(
    .BUS_W     (BUS_W),
    .PG_W      (PG_W),
    .DBLK_W    (DBLK_W),
    .BC_W      (BC_W),
    .NUM_BLOCKS(NUM_BLOCKS),
    .COL_W     (COL_W),
    .MARK_WCOL (MARK_COL / BPW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .aligned  (aligned),
    .len_zero (len_zero),
    .first_blk(first_blk),
    .last_blk (last_blk),
    .start_pg (start_pg),
    .seq_done (seq_done),
    .rd_data  (rd_data),
    .xfer_fin (xfer_fin),
    .seq_req  (seq_req),
    .seq_spare(seq_spare),
    .seq_row  (seq_row),
    .seq_col  (seq_col),
    .chk_rd   (chk_rd),
    .xfer_go  (xfer_go),
    .accept   (accept),
    .busy     (busy),
    .done     (done),
    .fault    (fault)
  );

  nil_stream #(
    .BUS_W (BUS_W),
    .ADDR_W(ADDR_W),
    .WPP   (WPP),
    .STEP  (BPW)
  ) u_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (accept),
    .ld_addr  (dst_base),
    .go       (xfer_go),
    .rd_data  (rd_data),
    .rd_en    (st_rd),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .fin      (xfer_fin)
  );

  assign rd_en = chk_rd | st_rd;

  // R2: marker strobe and page strobes never overlap
  a_r2_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
    !(chk_rd && st_rd));

  // R8: no strobe or write while idle
  a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!rd_en && !seq_req));

endmodule

// File: tb/nand_image_loader_tb.sv
module nand_image_loader_tb;
  localparam int PB  = 16;
  localparam int PPB = 4;
  localparam int NB  = 16;
  localparam int BB  = PB * PPB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  load_ofs = '0;
  logic [10:0] load_len = '0;
  logic [15:0] dst_base = '0;
  logic        busy, done, fault, seq_req, seq_spare, rd_en, mem_we;
  logic [5:0]  seq_row;
  logic [7:0]  seq_col, mem_wdata;
  logic [15:0] mem_addr;
  logic        seq_done = 1'b0;
  logic [7:0]  rd_data = '0;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  nand_image_loader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .load_ofs(load_ofs),
    .load_len(load_len), .dst_base(dst_base), .busy(busy), .done(done),
    .fault(fault), .seq_req(seq_req), .seq_spare(seq_spare),
    .seq_row(seq_row), .seq_col(seq_col), .seq_done(seq_done),
    .rd_en(rd_en), .rd_data(rd_data), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  logic [15:0] bad_map = '0;

  function automatic logic [7:0] mark_of(int b);
    if (!bad_map[b]) return 8'hFF;
    case (b % 3)
      0: return 8'h00;
      1: return 8'hFE;
      default: return 8'h7F;
    endcase
  endfunction

  function automatic logic [7:0] pat(int row, int w);
    return 8'((row * 13 + w * 5 + 3) & 255);
  endfunction

  // array and sequencer model plus logs
  int   cmd_n = 0, wr_n = 0, done_n = 0, viol_req = 0, viol_strb = 0;
  logic c_spare [0:1023];
  int   c_row   [0:1023];
  int   c_col   [0:1023];
  int   w_addr  [0:1023];
  int   w_data  [0:1023];
  logic cur_spare = 1'b0, prev_spare = 1'b0, sd_q = 1'b0, seen = 1'b0;
  int   cur_row = 0, widx = 0, strobes = 0, dly = 0;

  always @(posedge clk) begin
    if (seq_req && seq_done) begin
      c_spare[cmd_n % 1024] <= seq_spare;
      c_row[cmd_n % 1024]   <= int'(seq_row);
      c_col[cmd_n % 1024]   <= int'(seq_col);
      cmd_n      <= cmd_n + 1;
      cur_spare  <= seq_spare;
      cur_row    <= int'(seq_row);
      widx       <= 0;
      if (seen && prev_spare && strobes != 1) viol_strb <= viol_strb + 1;
      seen       <= 1'b1;
      prev_spare <= seq_spare;
      strobes    <= 0;
    end else if (rd_en) begin
      strobes <= strobes + 1;
    end
    if (rd_en) begin
      rd_data <= cur_spare ? mark_of(cur_row / PPB) : pat(cur_row, widx);
      if (!(seq_req && seq_done)) widx <= widx + 1;
    end
    if (seq_req && !seq_done) begin
      if (dly == 2) begin seq_done <= 1'b1; dly <= 0; end
      else dly <= dly + 1;
    end else begin
      seq_done <= 1'b0;
      dly <= 0;
    end
    sd_q <= seq_done;
    if (sd_q && seq_req) viol_req <= viol_req + 1;
    if (mem_we) begin
      w_addr[wr_n % 1024] <= int'(mem_addr);
      w_data[wr_n % 1024] <= int'(mem_wdata);
      wr_n <= wr_n + 1;
    end
    if (done) done_n <= done_n + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int cb, wb, db;

  task automatic kick(input int ofs, input int len, input int dst);
    @(negedge clk);
    cb = cmd_n; wb = wr_n; db = done_n;
    load_ofs = 10'(ofs); load_len = 11'(len); dst_base = 16'(dst);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 6000) begin @(negedge clk); n++; end
    @(negedge clk); @(negedge clk);
  endtask

  // model walk of the requirements, compared against the logs
  task automatic verify(input int ofs, input int len, input int dst);
    int blk = ofs / BB;
    int last = (ofs + len - 1) / BB;
    int pg = (ofs % BB) / PB;
    int ci = 0, wi = 0, cbad = 0, wbad = 0;
    bit exp_flt;
    while (blk <= last && blk < NB) begin
      if (ci < cmd_n - cb) begin
        int k = (cb + ci) % 1024;
        if (!(c_spare[k] == 1'b1 && c_row[k] == blk * PPB && c_col[k] == 0)) cbad++;
      end
      ci++;
      if (bad_map[blk]) begin
        last++;
      end else begin
        for (int p = pg; p < PPB; p++) begin
          if (ci < cmd_n - cb) begin
            int k = (cb + ci) % 1024;
            if (!(c_spare[k] == 1'b0 && c_row[k] == blk * PPB + p && c_col[k] == 0)) cbad++;
          end
          ci++;
          for (int w = 0; w < PB; w++) begin
            if (wi < wr_n - wb) begin
              int k = (wb + wi) % 1024;
              if (!(w_addr[k] == ((dst + wi) & 16'hFFFF) &&
                    w_data[k] == int'(pat(blk * PPB + p, w)))) wbad++;
            end
            wi++;
          end
        end
        pg = 0;
      end
      blk++;
    end
    exp_flt = (blk >= NB) && (blk <= last);
    chk(cmd_n - cb == ci, "R2/R6 command count", cmd_n - cb, ci);
    chk(cbad == 0, "R1/R4 command row/column", cbad, 0);
    chk(wr_n - wb == wi, "R7 write count", wr_n - wb, wi);
    chk(wbad == 0, "R5/R3 write address/data", wbad, 0);
    chk(fault == exp_flt, "R11 fault at end", int'(fault), int'(exp_flt));
    chk(done_n - db == 1, "R8 single done pulse", done_n - db, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lens [4] = '{1, 17, 64, 100};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !seq_req && !rd_en && !mem_we,
        "R8 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // main sweep: two bad maps, every page of three blocks, four lengths
    for (int m = 0; m < 2; m++) begin
      bad_map = (m == 0) ? 16'h0000 : 16'h0025;
      for (int o = 0; o < 12; o++) begin
        for (int l = 0; l < 4; l++) begin
          kick(o * PB, lens[l], 16'h0200 + o * 16);
          chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
          wait_done();
          verify(o * PB, lens[l], 16'h0200 + o * 16);
        end
      end
    end

    // R3: all three marker flavours in one pass (blocks 3,4,5)
    bad_map = 16'h0038;
    kick(3 * BB + PB, 130, 16'h0100);
    wait_done();
    verify(3 * BB + PB, 130, 16'h0100);

    // R11: bad tail pushes past the device end
    bad_map = 16'hC000;
    kick(13 * BB, 128, 16'h0040);
    wait_done();
    verify(13 * BB, 128, 16'h0040);
    bad_map = 16'h0000;
    kick(15 * BB, 200, 16'h0000);
    wait_done();
    verify(15 * BB, 200, 16'h0000);

    // R9: misaligned offset faults, stays idle, no commands or writes
    kick(PB + 3, 20, 16'h0300);
    chk(fault == 1'b1, "R9 fault on misaligned", int'(fault), 1);
    chk(busy == 1'b0, "R9 busy low", int'(busy), 0);
    repeat (10) @(negedge clk);
    chk(cmd_n == cb && wr_n == wb, "R9 no command or write", cmd_n - cb, 0);
    chk(done_n == db, "R9 no done", done_n - db, 0);

    // R10: zero length
    kick(2 * BB, 0, 16'h0300);
    chk(done == 1'b1 && busy == 1'b0, "R10 immediate done", int'(done), 1);
    chk(fault == 1'b0, "R9 fault cleared by accepted start", int'(fault), 0);
    repeat (6) @(negedge clk);
    chk(cmd_n == cb, "R10 no command", cmd_n - cb, 0);

    // R8: start while busy is ignored
    bad_map = 16'h0002;
    kick(PB * 2, 80, 16'h0500);
    repeat (30) @(negedge clk);
    start = 1'b1; load_ofs = 10'd5; load_len = 11'd3; dst_base = 16'h0000;
    @(negedge clk);
    start = 1'b0;
    load_ofs = 10'(PB * 2); load_len = 11'd80; dst_base = 16'h0500;
    wait_done();
    verify(PB * 2, 80, 16'h0500);

    chk(viol_req == 0, "R12 request drops after done", viol_req, 0);
    chk(viol_strb == 0, "R2 one strobe per marker read", viol_strb, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule